// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block is the address engine of a microcoded control unit. It holds the current control-store address in a register and, on every clock edge, loads the address of the next microinstruction. The next address comes from one of four places: the current address plus one, the branch target carried in the microinstruction, a single saved return address, or an address computed from the opcode of the machine instruction being executed. The current microinstruction supplies the branch target, a two-bit branch-mode field and a two-bit condition select. The datapath supplies three status flags and the instruction opcode.

A call stores the address after the call in the return register and then jumps. A later return jumps back to that saved address. The mapping mode places the routine of each opcode at a fixed stride of four words in the lower part of the control store, so a short routine fits there or a longer one can jump elsewhere. Reset starts execution at a fixed fetch-routine address.

Top module: `micro_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `car` loads `FETCH_ADDR` (default 64) and the return register clears to 0. Reset takes priority over every field value.
- R2: The tested condition is chosen by `cond_sel`. Code 0 is always true, 1 is `flag_sign`, 2 is `flag_indirect` and 3 is `flag_acc_zero`. The two flags that are not selected have no effect.
- R3: With `br_mode` = 0 (conditional jump), `car` loads `addr_field` when the condition is true. Otherwise it loads `car`+1.
- R4: With `br_mode` = 1 (conditional call) and the condition true, the return register loads `car`+1 and `car` loads `addr_field`. With the condition false, `car` loads `car`+1.
- R5: With `br_mode` = 2 (return), `car` loads the return register whatever the condition is, and the return register keeps its value.
- R6: With `br_mode` = 3 (map), `car` loads the opcode shifted left by two with zero upper bits (opcode 10 gives 40, opcode 15 gives 60), whatever the condition is.
- R7: The increment wraps modulo 2^`CAR_W`, so address 127 steps to 0 at the default width.
- R8: The return register changes only on a taken call or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_field | input | CAR_W | Branch target from the microinstruction |
| br_mode | input | 2 | Branch mode: 0 jump, 1 call, 2 return, 3 map |
| cond_sel | input | 2 | Condition select: 0 true, 1 sign, 2 indirect, 3 accumulator zero |
| flag_sign | input | 1 | Sign status bit |
| flag_indirect | input | 1 | Indirect-address status bit |
| flag_acc_zero | input | 1 | Accumulator-is-zero status bit |
| opcode | input | OPC_W | Opcode of the current machine instruction |
| car | output | CAR_W | Control-store address |

## Verification
A wrong select or a wrong condition shows on `car` at the very next edge as a wrong address: a target where an increment was due, or the reverse. A corrupted or wrongly loaded return register does not show right away. It appears only at the next return, which can come many cycles later. For that reason the stimulus places returns after calls that are not taken, after map steps, after a return that tests a false condition, and after a reset.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        BR_JUMP = 2'd0,
        BR_CALL = 2'd1,
        BR_RET  = 2'd2,
        BR_MAP  = 2'd3
    } br_mode_e;

    typedef enum logic [1:0] {
        CD_TRUE = 2'd0,
        CD_SIGN = 2'd1,
        CD_IND  = 2'd2,
        CD_ZERO = 2'd3
    } cond_sel_e;

    typedef enum logic [1:0] {
        SRC_INC = 2'd0,
        SRC_AD  = 2'd1,
        SRC_RET = 2'd2,
        SRC_MAP = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic sign;
        logic indirect;
        logic acc_zero;
    } status_t;

    typedef struct packed {
        src_sel_e src;
        logic     load_ret;
    } seq_ctl_t;

    function automatic seq_ctl_t decode_ctl(input br_mode_e mode, input logic t);
        seq_ctl_t c;
        logic i1, i0;
        i1 = mode[1];
        i0 = mode[0];
        c.src      = src_sel_e'({i1, (i1 & i0) | (~i1 & t)});
        c.load_ret = ~i1 & i0 & t;
        return c;
    endfunction

endpackage

// File: rtl/mseq_cond_sel.sv
module mseq_cond_sel
    import mseq_pkg::*;
(
    input  cond_sel_e cd,
    input  status_t   stat,
    output logic      t
);
    always_comb begin
        case (cd)
            CD_TRUE: t = 1'b1;
            CD_SIGN: t = stat.sign;
            CD_IND:  t = stat.indirect;
            CD_ZERO: t = stat.acc_zero;
            default: t = 1'b0;
        endcase
    end
endmodule

// File: rtl/mseq_next_sel.sv
module mseq_next_sel
    import mseq_pkg::*;
(
    input  br_mode_e mode,
    input  logic     t,
    output seq_ctl_t ctl
);
    always_comb ctl = decode_ctl(mode, t);
endmodule

// File: rtl/mseq_addr_mux.sv
module mseq_addr_mux
    import mseq_pkg::*;
#(
    parameter int CAR_W = 7,
    parameter int OPC_W = 4
) (
    input  src_sel_e           src,
    input  logic [CAR_W-1:0]   cur,
    input  logic [CAR_W-1:0]   ad,
    input  logic [CAR_W-1:0]   ret,
    input  logic [OPC_W-1:0]   opc,
    output logic [CAR_W-1:0]   inc,
    output logic [CAR_W-1:0]   nxt
);
    localparam int PAD_W = CAR_W - OPC_W - 2;

    logic [CAR_W-1:0] mapped;

    generate
        if (PAD_W > 0) begin : g_pad
            assign mapped = {{PAD_W{1'b0}}, opc, 2'b00};
        end else begin : g_nopad
            assign mapped = {opc, 2'b00};
        end
    endgenerate

    assign inc = cur + CAR_W'(1);

    always_comb begin
        case (src)
            SRC_INC: nxt = inc;
            SRC_AD:  nxt = ad;
            SRC_RET: nxt = ret;
            SRC_MAP: nxt = mapped;
            default: nxt = inc;
        endcase
    end
endmodule

// File: rtl/micro_seq.sv
module micro_seq
    import mseq_pkg::*;
#(
    parameter int CAR_W      = 7,
    parameter int OPC_W      = 4,
    parameter int FETCH_ADDR = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CAR_W-1:0] addr_field,
    input  logic [1:0]       br_mode,
    input  logic [1:0]       cond_sel,
    input  logic             flag_sign,
    input  logic             flag_indirect,
    input  logic             flag_acc_zero,
    input  logic [OPC_W-1:0] opcode,
    output logic [CAR_W-1:0] car
);
    localparam logic [CAR_W-1:0] FETCH_V = CAR_W'(FETCH_ADDR);

    status_t          stat;
    logic             t_cond;
    seq_ctl_t         ctl;
    logic [CAR_W-1:0] sbr;
    logic [CAR_W-1:0] inc_addr;
    logic [CAR_W-1:0] nxt_addr;

    assign stat = '{sign: flag_sign, indirect: flag_indirect, acc_zero: flag_acc_zero};

    mseq_cond_sel u_cond (
        .cd   (cond_sel_e'(cond_sel)),
        .stat (stat),
        .t    (t_cond)
    );

    mseq_next_sel u_sel (
        .mode (br_mode_e'(br_mode)),
        .t    (t_cond),
        .ctl  (ctl)
    );

    mseq_addr_mux #(.CAR_W(CAR_W), .OPC_W(OPC_W)) u_mux (
        .src (ctl.src),
        .cur (car),
        .ad  (addr_field),
        .ret (sbr),
        .opc (opcode),
        .inc (inc_addr),
        .nxt (nxt_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            car <= FETCH_V;
            sbr <= '0;
        end else begin
            car <= nxt_addr;
            if (ctl.load_ret) sbr <= inc_addr;
        end
    end
endmodule

// File: rtl/micro_seq_chk.sv
module micro_seq_chk #(
    parameter int CAR_W      = 7,
    parameter int OPC_W      = 4,
    parameter int FETCH_ADDR = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [CAR_W-1:0] addr_field,
    input logic [1:0]       br_mode,
    input logic [OPC_W-1:0] opcode,
    input logic             t_cond,
    input logic [CAR_W-1:0] sbr,
    input logic [CAR_W-1:0] car
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (car == CAR_W'(FETCH_ADDR) && sbr == '0));

    assert_jump_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (br_mode == 2'd0 && t_cond) |=> car == $past(addr_field));

    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        (br_mode[1] == 1'b0 && !t_cond) |=> car == CAR_W'($past(car) + 1'b1));

    assert_call_R4: assert property (@(posedge clk) disable iff (rst)
        (br_mode == 2'd1 && t_cond) |=>
            (car == $past(addr_field) && sbr == CAR_W'($past(car) + 1'b1)));

    assert_return_R5: assert property (@(posedge clk) disable iff (rst)
        (br_mode == 2'd2) |=> (car == $past(sbr) && $stable(sbr)));

    assert_map_R6: assert property (@(posedge clk) disable iff (rst)
        (br_mode == 2'd3) |=> car == CAR_W'({$past(opcode), 2'b00}));

    assert_sbr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(br_mode == 2'd1 && t_cond) |=> $stable(sbr));
endmodule

bind micro_seq micro_seq_chk #(.CAR_W(CAR_W), .OPC_W(OPC_W), .FETCH_ADDR(FETCH_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_field (addr_field),
    .br_mode    (br_mode),
    .opcode     (opcode),
    .t_cond     (t_cond),
    .sbr        (sbr),
    .car        (car)
);

// File: tb/sim_micro_seq.sv
`timescale 1ns/1ps
module sim_micro_seq;
    localparam int CAR_W = 7;
    localparam int OPC_W = 4;

    typedef struct packed {
        logic [1:0]       br;
        logic [1:0]       cd;
        logic [CAR_W-1:0] ad;
        logic             sgn;
        logic             ind;
        logic             zr;
        logic [OPC_W-1:0] opc;
        logic [CAR_W-1:0] exp;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 7'd10,  1'b0, 1'b0, 1'b0, 4'd0,  7'd10,  4'd3}, // R3 always-true jump
        '{2'd0, 2'd1, 7'd20,  1'b0, 1'b1, 1'b1, 4'd0,  7'd11,  4'd2}, // R2 sign clear, others ignored
        '{2'd0, 2'd1, 7'd20,  1'b1, 1'b0, 1'b0, 4'd0,  7'd20,  4'd2}, // R2 sign set
        '{2'd1, 2'd2, 7'd30,  1'b0, 1'b1, 1'b0, 4'd0,  7'd30,  4'd4}, // R4 call taken, ret=21
        '{2'd0, 2'd3, 7'd5,   1'b1, 1'b1, 1'b0, 4'd0,  7'd31,  4'd3}, // R3 zero clear -> step
        '{2'd2, 2'd0, 7'd0,   1'b0, 1'b0, 1'b0, 4'd0,  7'd21,  4'd5}, // R5 return
        '{2'd3, 2'd0, 7'd0,   1'b0, 1'b0, 1'b0, 4'd10, 7'd40,  4'd6}, // R6 map 10
        '{2'd1, 2'd2, 7'd50,  1'b1, 1'b0, 1'b1, 4'd0,  7'd41,  4'd4}, // R4 call not taken
        '{2'd2, 2'd0, 7'd0,   1'b0, 1'b0, 1'b0, 4'd0,  7'd21,  4'd8}, // R8 ret kept
        '{2'd0, 2'd3, 7'd100, 1'b0, 1'b0, 1'b1, 4'd0,  7'd100, 4'd2}, // R2 zero set
        '{2'd3, 2'd0, 7'd0,   1'b0, 1'b0, 1'b0, 4'd15, 7'd60,  4'd6}, // R6 map 15
        '{2'd2, 2'd0, 7'd0,   1'b0, 1'b0, 1'b0, 4'd0,  7'd21,  4'd5}, // R5 return again
        '{2'd0, 2'd0, 7'd127, 1'b0, 1'b0, 1'b0, 4'd0,  7'd127, 4'd3}, // R3 jump to top
        '{2'd0, 2'd1, 7'd0,   1'b0, 1'b0, 1'b0, 4'd0,  7'd0,   4'd7}, // R7 wrap
        '{2'd1, 2'd0, 7'd127, 1'b0, 1'b0, 1'b0, 4'd0,  7'd127, 4'd4}, // R4 call, ret=1
        '{2'd0, 2'd1, 7'd0,   1'b0, 1'b0, 1'b0, 4'd0,  7'd0,   4'd7}, // R7 wrap
        '{2'd2, 2'd0, 7'd0,   1'b0, 1'b0, 1'b0, 4'd0,  7'd1,   4'd4}  // R4 saved wrapped value
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CAR_W-1:0] addr_field = '0;
    logic [1:0]       br_mode = 2'd0;
    logic [1:0]       cond_sel = 2'd0;
    logic             flag_sign = 1'b0;
    logic             flag_indirect = 1'b0;
    logic             flag_acc_zero = 1'b0;
    logic [OPC_W-1:0] opcode = '0;
    logic [CAR_W-1:0] car;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    micro_seq u0 (
        .clk           (clk),
        .rst           (rst),
        .addr_field    (addr_field),
        .br_mode       (br_mode),
        .cond_sel      (cond_sel),
        .flag_sign     (flag_sign),
        .flag_indirect (flag_indirect),
        .flag_acc_zero (flag_acc_zero),
        .opcode        (opcode),
        .car           (car)
    );

    task automatic drive(input logic [1:0] br, input logic [1:0] cd, input logic [CAR_W-1:0] ad,
                         input logic s, input logic i, input logic z, input logic [OPC_W-1:0] op);
        br_mode = br; cond_sel = cd; addr_field = ad;
        flag_sign = s; flag_indirect = i; flag_acc_zero = z; opcode = op;
    endtask

    task automatic check(input string req, input logic [CAR_W-1:0] exp);
        checks++;
        if (car !== exp) begin
            failures++;
            $display("FAIL %s car=%0d expected=%0d", req, car, exp);
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog car=%0d expected=end of run", car);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check("R1", 7'd64);

        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].br, VECS[k].cd, VECS[k].ad, VECS[k].sgn, VECS[k].ind, VECS[k].zr, VECS[k].opc);
            rst = 1'b0;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].exp);
        end

        // R1: reset wins over a taken call and clears the return register
        rst = 1'b1;
        drive(2'd1, 2'd0, 7'd9, 1'b0, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        check("R1 reset over call", 7'd64);
        // R5: return on a false condition goes to the cleared return register
        rst = 1'b0;
        drive(2'd2, 2'd1, 7'd33, 1'b0, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        check("R5 return after reset", 7'd0);
        // R6: map ignores a false condition
        drive(2'd3, 2'd1, 7'd33, 1'b0, 1'b0, 1'b0, 4'd3);
        @(negedge clk);
        check("R6 map with false cond", 7'd12);
        // R2: indirect select, taken
        drive(2'd0, 2'd2, 7'd7, 1'b0, 1'b1, 1'b0, 4'd0);
        @(negedge clk);
        check("R2 indirect set", 7'd7);
        // R2: indirect select clear, other flags set -> step
        drive(2'd0, 2'd2, 7'd90, 1'b1, 1'b0, 1'b1, 4'd0);
        @(negedge clk);
        check("R2 indirect clear", 7'd8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule